// File: doc/BRIEF.md
# Composite Sync Separator

This block takes a digital composite sync signal, already on the local clock domain or at least slow enough to be brought in through a short synchronizer, and splits it into a horizontal sync output and a vertical sync output. A horizontal pulse of fixed width is started by each accepted falling edge of the input. After an edge is accepted, a window of most of a line ignores further falling edges. The half-line edges of the equalization and serration regions are removed this way, and one pulse per line is kept through the whole vertical interval.

Vertical sync is found by measuring how much of the recent input is low. A saturating up/down counter rises while the input is low and falls while it is high, which makes it a digital integrator. Vertical sync turns on at an upper threshold and off at a lower one. Short line pulses and equalization pulses never carry the counter near the upper threshold. The long low stretches of the vertical interval do.

A lock flag reports that the accepted edges have been arriving one line apart for a run of lines. Line length, pulse width, hold-off fraction, time-out fraction, integrator thresholds and ceiling, lock tolerance and lock run length are all parameters. The input is active low. All outputs are active high and come straight from registers.

Top module: `csync_separator`

## Requirements
- R1: An accepted falling edge of `csync_n_i` makes `hsync_o` go high on the third rising clock edge after the input is first sampled low, because of two synchronizer flops and one output register. It then stays high for exactly HSYNC_W clock cycles.
- R2: For HOLDOFF = floor(LINE_LEN*HOLDOFF_PCT/100) cycles after an accepted edge, further falling edges are ignored and do not restart the window. The first edge after the window is accepted. With the defaults of 64 and 95 the window is 60 cycles.
- R3: Across a vertical interval built from half-line equalization pulses and wide serration pulses, `hsync_o` gives exactly one pulse per line.
- R4: `vsync_o` rises only after the low-time integrator has reached VS_ON. Normal line pulses and equalization pulses never raise it.
- R5: Once `vsync_o` is high, it stays high until the integrator drops below VS_OFF. This hysteresis keeps it high through the early post-equalization pulses.
- R6: The integrator saturates at VS_CEIL. However long the input stays low, `vsync_o` therefore falls within roughly VS_CEIL-VS_OFF high cycles once the input returns high.
- R7: `lock_o` rises after LOCK_LINES consecutive accepted-edge spacings that each lie within LOCK_TOL cycles of LINE_LEN. It does not rise one spacing earlier.
- R8: Any accepted edge whose spacing from the previous accepted edge is out of tolerance clears `lock_o`. A rejected edge inside the hold-off window leaves `lock_o` unchanged.
- R9: If no edge is accepted for TIMEOUT = LINE_LEN*TIMEOUT_PCT/100 cycles, `lock_o` clears and the hold-off window is released, so the next falling edge is accepted at once.
- R10: The synchronous active-high `rst` drives `hsync_o`, `vsync_o` and `lock_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csync_n_i | input | 1 | Composite sync, active low, asynchronous to clk |
| hsync_o | output | 1 | Regenerated horizontal sync, active high |
| vsync_o | output | 1 | Recovered vertical sync, active high |
| lock_o | output | 1 | Line-rate lock indicator |

## Verification
A hold-off window that is too short or retriggered shows up within one line as a second horizontal pulse on a half-line edge, or as a missing pulse on the next line edge. A drifting integrator shows up within one vertical interval: `vsync_o` rises during equalization, fails to rise during serration, or stays high long after a long low. A wrong lock counter or spacing test shows up within a few lines: the flag comes one line early or late, or survives a late edge or a silent gap.

// File: rtl/csync_pkg.sv
package csync_pkg;
  // width of the measured spacing between accepted edges
  localparam int GAP_W = 16;

  // one event per clock from the horizontal separator to the lock tracker
  typedef struct packed {
    logic             acc;   // an edge was accepted this cycle
    logic             tmo;   // no edge accepted for the time-out span
    logic [GAP_W-1:0] gap;   // cycles since the previous accepted edge
  } line_evt_t;
endpackage

// File: rtl/csync_sync.sv
module csync_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din_n,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      last  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din_n};
      last  <= chain[STAGES-1];
    end
  end

  assign level_o = chain[STAGES-1];
  assign fall_o  = last & ~chain[STAGES-1];
endmodule

// File: rtl/csync_hsep.sv
module csync_hsep
  import csync_pkg::*;
#(
  parameter int LINE_LEN    = 64,
  parameter int HSYNC_W     = 5,
  parameter int HOLDOFF_PCT = 95,
  parameter int TIMEOUT_PCT = 150
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      fall_i,
  output logic      hsync_o,
  output line_evt_t evt_o
);
  localparam int HOLDOFF = LINE_LEN * HOLDOFF_PCT / 100;
  localparam int TIMEOUT = LINE_LEN * TIMEOUT_PCT / 100;
  localparam int CW      = $clog2(TIMEOUT + 1);
  localparam int PW      = $clog2(HSYNC_W + 1);

  logic [CW-1:0] since;
  logic          busy;
  logic [PW-1:0] pw;
  logic          accept;

  assign accept = fall_i & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      since   <= CW'(TIMEOUT);
      busy    <= 1'b0;
      pw      <= '0;
      hsync_o <= 1'b0;
      evt_o   <= '0;
    end else begin
      evt_o.acc <= accept;
      evt_o.gap <= GAP_W'(since) + GAP_W'(1);
      evt_o.tmo <= (since == CW'(TIMEOUT - 1)) && !accept;
      if (accept) begin
        since   <= '0;
        busy    <= 1'b1;
        pw      <= PW'(HSYNC_W);
        hsync_o <= 1'b1;
      end else begin
        if (since != CW'(TIMEOUT))
          since <= since + CW'(1);
        if (busy && ((since >= CW'(HOLDOFF - 1)) || (since >= CW'(TIMEOUT - 1))))
          busy <= 1'b0;
        if (pw > PW'(1)) begin
          pw <= pw - PW'(1);
        end else if (pw == PW'(1)) begin
          pw      <= '0;
          hsync_o <= 1'b0;
        end
      end
    end
  end

  // R1
  hsync_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync_o) |-> $past(fall_i));

  // R2
  holdoff_gap_chk: assert property (@(posedge clk) disable iff (rst)
    evt_o.acc |-> (int'(evt_o.gap) > HOLDOFF));
endmodule

// File: rtl/csync_vdet.sv
module csync_vdet #(
  parameter int VS_CEIL = 96,
  parameter int VS_ON   = 48,
  parameter int VS_OFF  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic vsync_o
);
  localparam int CW = $clog2(VS_CEIL + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      vsync_o <= 1'b0;
    end else begin
      if (!level_i) begin
        if (cnt != CW'(VS_CEIL)) cnt <= cnt + CW'(1);
      end else begin
        if (cnt != '0) cnt <= cnt - CW'(1);
      end
      if (cnt >= CW'(VS_ON))
        vsync_o <= 1'b1;
      else if (cnt < CW'(VS_OFF))
        vsync_o <= 1'b0;
    end
  end

  // R4
  vs_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync_o) |-> ($past(cnt) >= CW'(VS_ON)));

  // R5
  vs_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(vsync_o) |-> ($past(cnt) < CW'(VS_OFF)));

  // R6
  integ_ceil_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(VS_CEIL));
endmodule

// File: rtl/csync_lock.sv
module csync_lock
  import csync_pkg::*;
#(
  parameter int LINE_LEN   = 64,
  parameter int LOCK_TOL   = 2,
  parameter int LOCK_LINES = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  line_evt_t evt_i,
  output logic      lock_o
);
  localparam int SW = $clog2(LOCK_LINES + 1);

  logic [SW-1:0] streak;
  logic          good;

  assign good = evt_i.acc
             && (int'(evt_i.gap) >= LINE_LEN - LOCK_TOL)
             && (int'(evt_i.gap) <= LINE_LEN + LOCK_TOL);

  always_ff @(posedge clk) begin
    if (rst) begin
      streak <= '0;
      lock_o <= 1'b0;
    end else if (evt_i.tmo || (evt_i.acc && !good)) begin
      streak <= '0;
      lock_o <= 1'b0;
    end else if (good) begin
      if (streak >= SW'(LOCK_LINES - 1)) begin
        lock_o <= 1'b1;
        streak <= SW'(LOCK_LINES);
      end else begin
        streak <= streak + SW'(1);
      end
    end
  end

  // R7
  lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> $past(evt_i.acc));

  // R8 R9
  lock_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_o) |-> $past(evt_i.acc || evt_i.tmo));
endmodule

// File: rtl/csync_separator.sv
module csync_separator
  import csync_pkg::*;
#(
  parameter int LINE_LEN    = 64,
  parameter int HSYNC_W     = 5,
  parameter int HOLDOFF_PCT = 95,
  parameter int TIMEOUT_PCT = 150,
  parameter int VS_CEIL     = 96,
  parameter int VS_ON       = 48,
  parameter int VS_OFF      = 16,
  parameter int LOCK_TOL    = 2,
  parameter int LOCK_LINES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic csync_n_i,
  output logic hsync_o,
  output logic vsync_o,
  output logic lock_o
);
  logic      level;
  logic      fall;
  line_evt_t evt;

  csync_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .din_n(csync_n_i), .level_o(level), .fall_o(fall)
  );

  csync_hsep #(
    .LINE_LEN(LINE_LEN), .HSYNC_W(HSYNC_W),
    .HOLDOFF_PCT(HOLDOFF_PCT), .TIMEOUT_PCT(TIMEOUT_PCT)
  ) hsep_i (
    .clk(clk), .rst(rst), .fall_i(fall), .hsync_o(hsync_o), .evt_o(evt)
  );

  csync_vdet #(.VS_CEIL(VS_CEIL), .VS_ON(VS_ON), .VS_OFF(VS_OFF)) vdet_i (
    .clk(clk), .rst(rst), .level_i(level), .vsync_o(vsync_o)
  );

  csync_lock #(.LINE_LEN(LINE_LEN), .LOCK_TOL(LOCK_TOL), .LOCK_LINES(LOCK_LINES)) lock_i (
    .clk(clk), .rst(rst), .evt_i(evt), .lock_o(lock_o)
  );
endmodule

// File: tb/csync_separator_tb.sv
module csync_separator_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csync_n = 1'b1;
  logic hsync, vsync, lock;

  int tests = 0;
  int fails = 0;

  int hs_rises = 0;
  int hs_run   = 0;
  int last_w   = 0;
  int vs_cycles = 0;
  logic hs_prev = 1'b0;

  always #2 clk = ~clk;

  csync_separator dut_i (
    .clk(clk), .rst(rst), .csync_n_i(csync_n),
    .hsync_o(hsync), .vsync_o(vsync), .lock_o(lock)
  );

  always @(negedge clk) begin
    if (hsync && !hs_prev) hs_rises++;
    if (hsync) hs_run++;
    else if (hs_prev) begin last_w = hs_run; hs_run = 0; end
    if (vsync) vs_cycles++;
    hs_prev = hsync;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit lvl, input int n);
    csync_n = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_line(input int low, input int len);
    drive(1'b0, low);
    drive(1'b1, len - low);
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(hsync == 1'b0, "R10 hsync after reset", int'(hsync), 0);
    chk(vsync == 1'b0, "R10 vsync after reset", int'(vsync), 0);
    chk(lock == 1'b0,  "R10 lock after reset",  int'(lock), 0);
    drive(1'b1, 100);
  endtask

  task automatic t_edge_align;
    csync_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(hsync == 1'b0, "R1 no pulse before third edge", int'(hsync), 0);
    @(negedge clk);
    chk(hsync == 1'b1, "R1 pulse on third edge", int'(hsync), 1);
    repeat (2) @(negedge clk);
    drive(1'b1, 59);
    chk(last_w == 5, "R1 pulse width", last_w, 5);
  endtask

  task automatic t_lock;
    repeat (7) send_line(5, 64);
    chk(lock == 1'b0, "R7 not locked after 7 spacings", int'(lock), 0);
    send_line(5, 64);
    chk(lock == 1'b1, "R7 locked after 8 spacings", int'(lock), 1);
  endtask

  task automatic t_vertical;
    int r0, v0;
    r0 = hs_rises;
    v0 = vs_cycles;
    repeat (6) send_line(2, 32);
    chk(vs_cycles == v0, "R4 no vsync during equalization", vs_cycles - v0, 0);
    v0 = vs_cycles;
    repeat (6) send_line(27, 32);
    chk(vs_cycles > v0, "R4 vsync during serration", vs_cycles - v0, 1);
    repeat (2) send_line(2, 32);
    chk(vsync == 1'b1, "R5 hysteresis holds vsync", int'(vsync), 1);
    repeat (4) send_line(2, 32);
    chk(vsync == 1'b0, "R5 vsync released", int'(vsync), 0);
    chk(hs_rises - r0 == 9, "R3 one hsync per line in vertical", hs_rises - r0, 9);
    chk(last_w == 5, "R3 pulse width in vertical", last_w, 5);
    repeat (2) send_line(5, 64);
    chk(lock == 1'b1, "R2 lock kept through vertical", int'(lock), 1);
  endtask

  task automatic t_early_edge;
    int r0;
    r0 = hs_rises;
    send_line(5, 40);
    send_line(5, 24);
    chk(hs_rises - r0 == 1, "R2 edge inside hold-off ignored", hs_rises - r0, 1);
    send_line(5, 64);
    chk(hs_rises - r0 == 2, "R2 edge after hold-off accepted", hs_rises - r0, 2);
    chk(lock == 1'b1, "R8 rejected edge keeps lock", int'(lock), 1);
  endtask

  task automatic t_spacing;
    send_line(5, 66);
    send_line(5, 64);
    chk(lock == 1'b1, "R7 spacing within tolerance keeps lock", int'(lock), 1);
    send_line(5, 70);
    send_line(5, 64);
    chk(lock == 1'b0, "R8 late edge clears lock", int'(lock), 0);
    repeat (9) send_line(5, 64);
    chk(lock == 1'b1, "R7 relock", int'(lock), 1);
  endtask

  task automatic t_timeout;
    drive(1'b1, 120);
    chk(lock == 1'b0, "R9 silence clears lock", int'(lock), 0);
    csync_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(hsync == 1'b1, "R9 next edge accepted at once", int'(hsync), 1);
  endtask

  task automatic t_ceiling;
    drive(1'b0, 300);
    chk(vsync == 1'b1, "R4 long low raises vsync", int'(vsync), 1);
    drive(1'b1, 70);
    chk(vsync == 1'b1, "R6 vsync held after 70 high", int'(vsync), 1);
    drive(1'b1, 30);
    chk(vsync == 1'b0, "R6 saturated integrator releases", int'(vsync), 0);
  endtask

  initial begin
    t_reset();
    t_edge_align();
    t_lock();
    t_vertical();
    t_early_edge();
    t_spacing();
    t_timeout();
    t_ceiling();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule